// File: doc/BRIEF.md
# Masked Interrupt Status and Acknowledge Unit

This unit keeps a vector of pending interrupt flags next to an enable mask and drives an active-low interrupt request toward a host. Event sources raise flags through one-cycle set pulses. A peripheral reply engine can also deposit a reply of up to `DEPTH` bytes into an internal buffer. Such a reply is either a direct answer to a host command or an unsolicited auto-poll reply, and depositing it raises the reply flag.

The host services the line with an acknowledge strobe that carries an argument count. An accepted acknowledge is read-to-clear. When a reply is pending, only the reply and auto-poll flags are reported and cleared, and the buffered reply bytes follow them. Every other pending flag survives for a later acknowledge. When no reply is pending, the whole pending vector is reported in a single byte and then cleared. The response leaves as a stream of one byte per cycle, with its total length held steady on a separate output.

A two-state sequencer controls the acknowledge. In `ST_IDLE` it waits for a valid acknowledge, and the transition `ack_go` snapshots the response and applies the clears. In `ST_SEND` it presents one byte per cycle. The transition `last_byte` returns it to `ST_IDLE` in the cycle after the final byte has been presented.

Top module: `intr_ack_unit`

## Requirements
- R1: `irq_n` is 0 exactly when `pending & mask` is nonzero, and 1 otherwise. It takes its new value at the same clock edge that changes `pending` or `mask`.
- R2: After reset, `mask` holds the tick bit (bit 3) and the reply bit (bit 4), which is value 0x18. `pending` is 0, `irq_n` is 1 and `resp_valid` is 0.
- R3: A mask write with `mask_argc` equal to 1 loads `mask_data` into `mask`. A mask write with any other argument count leaves `mask` unchanged.
- R4: Suppose an acknowledge is accepted while the reply bit (bit 4) is pending. The first response byte then equals `pending` masked to the reply bit and the auto-poll bit (bit 6). The buffered reply bytes follow in buffer order, so `resp_len` is the buffer size plus 1. The acknowledge clears only bits 4 and 6 and empties the buffer, and every other pending bit stays set.
- R5: Suppose an acknowledge is accepted while bit 4 is not pending. The response is then one byte equal to the whole `pending` vector, with `resp_len` equal to 1, and all pending bits are cleared.
- R6: An acknowledge with `ack_argc` other than 0 has no effect: no response is produced and `pending` is unchanged. An acknowledge that arrives while a response is still streaming is also ignored.
- R7: An auto-poll reply (`reply_load` with `reply_auto` equal to 1) is accepted only if bit 4 was not pending before that cycle. Accepting it sets bits 4 and 6 and loads the buffer. A rejected reply leaves the buffer and the pending bits unchanged.
- R8: A direct reply (`reply_load` with `reply_auto` equal to 0) is always accepted. It overwrites the buffer and sets bit 4 only.
- R9: When a set (from a source pulse or an accepted reply) and an acknowledge clear hit the same bit in the same cycle, the bit ends up set.
- R10: Response bytes appear with `resp_valid` equal to 1, one per cycle, starting in the cycle after the acknowledge is accepted, with `resp_len` held for the whole stream. A reply length above `DEPTH` is clamped to `DEPTH`. Reply byte i is taken from `reply_data[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | W | One-cycle set pulses, one per pending bit |
| mask_wr | input | 1 | Mask write strobe |
| mask_argc | input | ARGW | Argument byte count of the mask write |
| mask_data | input | W | New mask value |
| reply_load | input | 1 | Deposit a peripheral reply |
| reply_auto | input | 1 | 1 marks the reply as auto-poll, 0 marks it as direct |
| reply_len | input | LENW | Reply byte count, clamped to DEPTH |
| reply_data | input | 8*DEPTH | Reply bytes, byte 0 in the lowest lane |
| ack_req | input | 1 | Acknowledge strobe |
| ack_argc | input | ARGW | Argument byte count of the acknowledge |
| irq_n | output | 1 | Active-low interrupt request |
| resp_valid | output | 1 | A response byte is present |
| resp_byte | output | 8 | Current response byte |
| resp_len | output | LENW | Total bytes in the current response |

## Verification
A corrupted pending or mask register becomes visible at the ports at the next clock edge, because `irq_n` disagrees with what the events so far imply. It also shows in the byte returned by the next acknowledge. A wrong reply-buffer size or a wrong sequencer state shows up one cycle after the acknowledge, either as a wrong `resp_len` or as `resp_valid` staying high too long or dropping too early. A lost set, or a clear applied to the wrong bits, stays hidden until the following acknowledge reports the surviving flags. The directed scenarios therefore finish with such an acknowledge.

// File: rtl/intr_ack_pkg.sv
package intr_ack_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } ack_state_e;
endpackage

// File: rtl/intr_pend_reg.sv
module intr_pend_reg #(
    parameter int          W        = 8,
    parameter logic [7:0]  RST_MASK = 8'h18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] pend,
    output logic [W-1:0] mask,
    output logic         irq_n
);
    logic [W-1:0] pend_n;
    logic [W-1:0] mask_n;

    // set has priority over clear so that no event is lost
    always_comb begin
        pend_n = (pend & ~clr_vec) | set_vec;
        mask_n = mask_we ? mask_wdata : mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            mask  <= W'(RST_MASK);
            irq_n <= 1'b1;
        end else begin
            pend  <= pend_n;
            mask  <= mask_n;
            irq_n <= ~|(pend_n & mask_n);
        end
    end

    assert_irq_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (irq_n == ~|(pend & mask)));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((pend & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/intr_reply_buf.sv
module intr_reply_buf #(
    parameter int DEPTH = 8,
    parameter int LENW  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [LENW-1:0]    ld_len,
    input  logic [DEPTH*8-1:0] ld_data,
    input  logic               clr,
    output logic [LENW-1:0]    size,
    output logic [DEPTH*8-1:0] data
);
    localparam logic [LENW-1:0] MAXLEN = LENW'(DEPTH);

    logic [LENW-1:0] eff_len;

    always_comb eff_len = (ld_len > MAXLEN) ? MAXLEN : ld_len;

    // a load in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (!rst_n)      size <= '0;
        else if (ld_en)  size <= eff_len;
        else if (clr)    size <= '0;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)     data[8*g +: 8] <= 8'h00;
            else if (ld_en) data[8*g +: 8] <= ld_data[8*g +: 8];
        end
    end

    assert_size_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (size <= MAXLEN));
endmodule

// File: rtl/intr_ack_seq.sv
module intr_ack_seq
    import intr_ack_pkg::*;
#(
    parameter int W        = 8,
    parameter int DEPTH    = 8,
    parameter int LENW     = 4,
    parameter int ARGW     = 4,
    parameter int RPLY_BIT = 4,
    parameter int AUTO_BIT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_req,
    input  logic [ARGW-1:0]    ack_argc,
    input  logic [W-1:0]       pend,
    input  logic [LENW-1:0]    rsize,
    input  logic [DEPTH*8-1:0] rdata,
    output logic [W-1:0]       clr_vec,
    output logic               rclr,
    output logic               resp_valid,
    output logic [7:0]         resp_byte,
    output logic [LENW-1:0]    resp_len
);
    localparam int          IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [W-1:0] PAIR = (W'(1) << RPLY_BIT) | (W'(1) << AUTO_BIT);

    ack_state_e      state, state_n;
    logic [LENW-1:0] idx;
    logic [LENW-1:0] len_q;
    logic [7:0]      head;
    logic [7:0]      snap [DEPTH];
    logic            ack_go;
    logic            has_reply;
    logic            last_byte;
    logic [IW-1:0]   sidx;

    always_comb begin
        has_reply = pend[RPLY_BIT];
        ack_go    = (state == ST_IDLE) && ack_req && (ack_argc == '0);
        last_byte = (idx == len_q - LENW'(1));
        clr_vec   = '0;
        rclr      = 1'b0;
        state_n   = state;
        unique case (state)
            ST_IDLE: begin
                if (ack_go) begin
                    state_n = ST_SEND;
                    if (has_reply) begin
                        clr_vec = PAIR;
                        rclr    = 1'b1;
                    end else begin
                        clr_vec = '1;
                    end
                end
            end
            ST_SEND: begin
                if (last_byte) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            len_q <= '0;
            head  <= 8'h00;
        end else begin
            state <= state_n;
            if (ack_go) begin
                idx   <= '0;
                head  <= 8'(has_reply ? (pend & PAIR) : pend);
                len_q <= has_reply ? (rsize + LENW'(1)) : LENW'(1);
            end else if (state == ST_SEND) begin
                idx <= idx + LENW'(1);
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_snap
        always_ff @(posedge clk) begin
            if (!rst_n)      snap[g] <= 8'h00;
            else if (ack_go) snap[g] <= rdata[8*g +: 8];
        end
    end

    always_comb begin
        sidx       = IW'(idx - LENW'(1));
        resp_valid = (state == ST_SEND);
        resp_len   = len_q;
        resp_byte  = 8'h00;
        if (state == ST_SEND) resp_byte = (idx == '0) ? head : snap[sidx];
    end

    assert_ack_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ack_req && ack_argc != '0) |=> !resp_valid);

    assert_stream_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_len != '0 && idx < resp_len));

    assert_stream_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_go |=> (resp_valid && idx == '0));
endmodule

// File: rtl/intr_ack_unit.sv
module intr_ack_unit #(
    parameter int  W        = 8,
    parameter int  DEPTH    = 8,
    parameter int  ARGW     = 4,
    parameter int  TICK_BIT = 3,
    parameter int  RPLY_BIT = 4,
    parameter int  AUTO_BIT = 6,
    localparam int LENW     = $clog2(DEPTH + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       src_set,
    input  logic               mask_wr,
    input  logic [ARGW-1:0]    mask_argc,
    input  logic [W-1:0]       mask_data,
    input  logic               reply_load,
    input  logic               reply_auto,
    input  logic [LENW-1:0]    reply_len,
    input  logic [DEPTH*8-1:0] reply_data,
    input  logic               ack_req,
    input  logic [ARGW-1:0]    ack_argc,
    output logic               irq_n,
    output logic               resp_valid,
    output logic [7:0]         resp_byte,
    output logic [LENW-1:0]    resp_len
);
    localparam logic [W-1:0] RBIT     = W'(1) << RPLY_BIT;
    localparam logic [W-1:0] ABIT     = W'(1) << AUTO_BIT;
    localparam logic [7:0]   RST_MASK = 8'((W'(1) << TICK_BIT) | RBIT);

    logic [W-1:0]       pend;
    logic [W-1:0]       mask;
    logic [W-1:0]       clr_vec;
    logic [W-1:0]       set_vec;
    logic               rclr;
    logic               reply_ok;
    logic               mask_we;
    logic [LENW-1:0]    rsize;
    logic [DEPTH*8-1:0] rdata;

    always_comb begin
        mask_we  = mask_wr && (mask_argc == ARGW'(1));
        reply_ok = reply_load && (!reply_auto || !pend[RPLY_BIT]);
        set_vec  = src_set;
        if (reply_ok) set_vec = set_vec | RBIT | (reply_auto ? ABIT : '0);
    end

    intr_pend_reg #(.W(W), .RST_MASK(RST_MASK)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec),
        .mask_we    (mask_we),
        .mask_wdata (mask_data),
        .pend       (pend),
        .mask       (mask),
        .irq_n      (irq_n)
    );

    intr_reply_buf #(.DEPTH(DEPTH), .LENW(LENW)) u_rbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (reply_ok),
        .ld_len  (reply_len),
        .ld_data (reply_data),
        .clr     (rclr),
        .size    (rsize),
        .data    (rdata)
    );

    intr_ack_seq #(
        .W(W), .DEPTH(DEPTH), .LENW(LENW), .ARGW(ARGW),
        .RPLY_BIT(RPLY_BIT), .AUTO_BIT(AUTO_BIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_req    (ack_req),
        .ack_argc   (ack_argc),
        .pend       (pend),
        .rsize      (rsize),
        .rdata      (rdata),
        .clr_vec    (clr_vec),
        .rclr       (rclr),
        .resp_valid (resp_valid),
        .resp_byte  (resp_byte),
        .resp_len   (resp_len)
    );

    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_wr && mask_argc == ARGW'(1)) |=> (mask == $past(mask)));

    assert_reply_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rclr && !reply_load && !src_set[RPLY_BIT] && !src_set[AUTO_BIT])
        |=> (!pend[RPLY_BIT] && !pend[AUTO_BIT] && rsize == '0));

    assert_auto_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_load && reply_auto && pend[RPLY_BIT] && !rclr) |=> $stable(rsize));

    assert_direct_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_load && !reply_auto) |=> pend[RPLY_BIT]);
endmodule

// File: tb/test_intr_ack_unit.sv
module test_intr_ack_unit;
    localparam int W = 8, DEPTH = 8, ARGW = 4, LENW = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [W-1:0]       src_set = '0;
    logic               mask_wr = 1'b0;
    logic [ARGW-1:0]    mask_argc = '0;
    logic [W-1:0]       mask_data = '0;
    logic               reply_load = 1'b0;
    logic               reply_auto = 1'b0;
    logic [LENW-1:0]    reply_len = '0;
    logic [DEPTH*8-1:0] reply_data = '0;
    logic               ack_req = 1'b0;
    logic [ARGW-1:0]    ack_argc = '0;
    logic               irq_n;
    logic               resp_valid;
    logic [7:0]         resp_byte;
    logic [LENW-1:0]    resp_len;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_b [10];

    always #10 clk = ~clk;

    intr_ack_unit i_intr_ack_unit (
        .clk(clk), .rst_n(rst_n), .src_set(src_set),
        .mask_wr(mask_wr), .mask_argc(mask_argc), .mask_data(mask_data),
        .reply_load(reply_load), .reply_auto(reply_auto),
        .reply_len(reply_len), .reply_data(reply_data),
        .ack_req(ack_req), .ack_argc(ack_argc),
        .irq_n(irq_n), .resp_valid(resp_valid),
        .resp_byte(resp_byte), .resp_len(resp_len)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [7:0] v);
        @(negedge clk) src_set = v;
        @(negedge clk) src_set = '0;
    endtask

    task automatic write_mask(input int argc, input logic [7:0] v);
        @(negedge clk) begin mask_wr = 1; mask_argc = ARGW'(argc); mask_data = v; end
        @(negedge clk) mask_wr = 0;
    endtask

    task automatic load(input bit aut, input int len,
                        input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        @(negedge clk) begin
            reply_load = 1; reply_auto = aut; reply_len = LENW'(len);
            reply_data = '0;
            reply_data[7:0] = b0; reply_data[15:8] = b1; reply_data[23:16] = b2;
        end
        @(negedge clk) reply_load = 0;
    endtask

    // n expected bytes in exp_b; hold keeps ack_req high through the stream
    task automatic ack_expect(input int n, input bit hold, input string tag);
        @(negedge clk) begin ack_req = 1; ack_argc = '0; end
        @(negedge clk) if (!hold) ack_req = 0;
        for (int k = 0; k < n; k++) begin
            check(resp_valid === 1'b1, {tag, " valid"}, resp_valid, 1);
            check(resp_len === LENW'(n), {tag, " len"}, resp_len, n);
            check(resp_byte === exp_b[k], {tag, " byte"}, resp_byte, exp_b[k]);
            if (k < n - 1) @(negedge clk);
        end
        @(negedge clk) ack_req = 0;
        check(resp_valid === 1'b0, {tag, " end"}, resp_valid, 0);
        @(negedge clk);
        check(resp_valid === 1'b0, {tag, " idle"}, resp_valid, 0);
    endtask

    task automatic t_reset_R2();
        check(irq_n === 1'b1, "R2 irq_n", irq_n, 1);
        check(resp_valid === 1'b0, "R2 resp_valid", resp_valid, 0);
        exp_b[0] = 8'h00;
        ack_expect(1, 0, "R2 empty pending");
        pulse(8'h01);
        check(irq_n === 1'b1, "R2 bit0 unmasked", irq_n, 1);
        pulse(8'h08);
        check(irq_n === 1'b0, "R1 tick masked in", irq_n, 0);
        exp_b[0] = 8'h09;
        ack_expect(1, 0, "R5 ack all");
        check(irq_n === 1'b1, "R1 irq released", irq_n, 1);
    endtask

    task automatic t_mask_R3();
        write_mask(2, 8'h01);
        pulse(8'h01);
        check(irq_n === 1'b1, "R3 bad argc ignored", irq_n, 1);
        write_mask(1, 8'h01);
        check(irq_n === 1'b0, "R3 mask loaded R1", irq_n, 0);
        exp_b[0] = 8'h01;
        ack_expect(1, 0, "R3 ack");
        write_mask(1, 8'h18);
    endtask

    task automatic t_plain_R5();
        pulse(8'h24);
        check(irq_n === 1'b1, "R1 unmasked bits", irq_n, 1);
        exp_b[0] = 8'h24;
        ack_expect(1, 0, "R5 whole vector");
        exp_b[0] = 8'h00;
        ack_expect(1, 0, "R5 cleared");
    endtask

    task automatic t_reply_R4();
        load(1, 3, 8'hAA, 8'hBB, 8'hCC);
        pulse(8'h08);
        check(irq_n === 1'b0, "R1 reply irq", irq_n, 0);
        exp_b[0] = 8'h50; exp_b[1] = 8'hAA; exp_b[2] = 8'hBB; exp_b[3] = 8'hCC;
        ack_expect(4, 0, "R4 reply first");
        check(irq_n === 1'b0, "R4 tick survives", irq_n, 0);
        exp_b[0] = 8'h08;
        ack_expect(1, 0, "R4 tick later");
        check(irq_n === 1'b1, "R1 all clear", irq_n, 1);
    endtask

    task automatic t_auto_R7_R8();
        load(1, 2, 8'h11, 8'h22, 8'h00);
        load(1, 1, 8'h77, 8'h00, 8'h00);
        exp_b[0] = 8'h50; exp_b[1] = 8'h11; exp_b[2] = 8'h22;
        ack_expect(3, 0, "R7 reject while pending");
        load(1, 2, 8'h11, 8'h22, 8'h00);
        load(0, 1, 8'h33, 8'h00, 8'h00);
        exp_b[0] = 8'h50; exp_b[1] = 8'h33;
        ack_expect(2, 0, "R8 direct overwrites");
        load(0, 2, 8'h44, 8'h55, 8'h00);
        exp_b[0] = 8'h10; exp_b[1] = 8'h44; exp_b[2] = 8'h55;
        ack_expect(3, 0, "R8 reply bit only");
    endtask

    task automatic t_ignore_R6();
        pulse(8'h08);
        @(negedge clk) begin ack_req = 1; ack_argc = 4'd1; end
        @(negedge clk) begin ack_req = 0; ack_argc = '0; end
        check(resp_valid === 1'b0, "R6 argc ack no resp", resp_valid, 0);
        @(negedge clk);
        check(resp_valid === 1'b0, "R6 argc ack no resp2", resp_valid, 0);
        check(irq_n === 1'b0, "R6 pending kept", irq_n, 0);
        exp_b[0] = 8'h08;
        ack_expect(1, 0, "R6 pending unchanged");
        load(1, 2, 8'h66, 8'h77, 8'h00);
        exp_b[0] = 8'h50; exp_b[1] = 8'h66; exp_b[2] = 8'h77;
        ack_expect(3, 1, "R6 ack during stream");
    endtask

    task automatic t_setwins_R9();
        pulse(8'h08);
        @(negedge clk) begin ack_req = 1; ack_argc = '0; src_set = 8'h08; end
        @(negedge clk) begin ack_req = 0; src_set = '0; end
        check(resp_byte === 8'h08, "R9 snapshot", resp_byte, 8'h08);
        @(negedge clk);
        check(irq_n === 1'b0, "R9 set survives clear", irq_n, 0);
        exp_b[0] = 8'h08;
        ack_expect(1, 0, "R9 bit still pending");
    endtask

    task automatic t_clamp_R10();
        @(negedge clk) begin
            reply_load = 1; reply_auto = 0; reply_len = 4'd12;
            for (int i = 0; i < DEPTH; i++) reply_data[8*i +: 8] = 8'(i + 1);
        end
        @(negedge clk) reply_load = 0;
        exp_b[0] = 8'h10;
        for (int i = 0; i < DEPTH; i++) exp_b[i + 1] = 8'(i + 1);
        ack_expect(9, 0, "R10 clamp to depth");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_R2();
        t_mask_R3();
        t_plain_R5();
        t_reply_R4();
        t_auto_R7_R8();
        t_ignore_R6();
        t_setwins_R9();
        t_clamp_R10();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule